// File: doc/BRIEF.md
# Dual Tri-State Phase Detector with Lock Indication

This block holds two independent digital phase/frequency comparators, one for the transmit synthesizer loop and one for the receive loop. Each comparator takes a divided reference strobe and a divided feedback strobe. Each strobe is a single-cycle pulse that marks one divided edge. The comparator drives a three-level pump control, modelled as separate pull-up and pull-down enables plus a high-impedance flag. If the feedback edge arrives late or runs slow, the block pulls up for as long as the lag lasts. If the feedback edge arrives early or runs fast, it pulls down for as long as the lead lasts. When both edges coincide, the output floats.

Each loop also has a lock qualifier with an active-low output. A comparison is good when its phase error is no wider than a fixed window of `LOCK_WIN` clocks. Lock is declared after a programmable number of consecutive good comparisons. A single comparison that exceeds the window drops lock immediately, even while that comparison is still open.

One shared status pin carries either an external carrier-detect level or the transmit loop's active-low lock flag, chosen by a select bit. All pins are plain control and status signals. Nothing flows as a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pfd_lock_pair`

## Requirements
- R1: From idle, a reference strobe without a feedback strobe raises the loop's up output in the next cycle. Up stays high until the cycle after a feedback strobe is sampled, so its width in cycles equals the lag between the two strobes. Down stays low throughout.
- R2: From idle, a feedback strobe without a reference strobe raises down in the next cycle. Down stays high until the cycle after a reference strobe is sampled, so its width equals the lead. Up stays low throughout.
- R3: From idle, reference and feedback strobes in the same cycle leave up and down low and the high-impedance flag high. This counts as a completed comparison with zero error.
- R4: Further reference strobes while up is open keep up high and down low (slow feedback). Further feedback strobes while down is open keep down high (fast feedback).
- R5: Up and down are never high together. The high-impedance flag is high exactly when both are low.
- R6: If both strobes arrive in the same cycle while a pulse is open, the open comparison closes and a new one of the same direction starts. The pulse stays high until the next closing strobe.
- R7: A comparison that closes with an error of at most LOCK_WIN cycles counts as good. lock_n goes low in the cycle after the closing strobe of the lock_count-th consecutive good comparison; a lock_count of 0 acts as 1. The good count saturates at its all-ones value.
- R8: An open pulse that has lasted LOCK_WIN cycles, with no closing strobe sampled in that cycle, clears lock and the good count. lock_n is high in the same cycle in which the pulse starts its next high cycle. A closed comparison with an error above LOCK_WIN has the same effect.
- R9: After reset, both loops are idle: up and down low, high-impedance high, lock_n high.
- R10: status_out equals carrier_det when status_sel is 0 and tx_lock_n when status_sel is 1. The receive lock flag never reaches status_out.
- R11: Strobes on one loop have no effect on the other loop's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_ref_stb | input | 1 | Transmit loop divided reference strobe (one-cycle pulse) |
| tx_fb_stb | input | 1 | Transmit loop divided feedback strobe (one-cycle pulse) |
| rx_ref_stb | input | 1 | Receive loop divided reference strobe |
| rx_fb_stb | input | 1 | Receive loop divided feedback strobe |
| lock_count | input | LC_W | Consecutive good comparisons required for lock (0 acts as 1) |
| status_sel | input | 1 | Status pin select: 0 carrier detect, 1 transmit lock |
| carrier_det | input | 1 | External carrier-detect level |
| tx_up | output | 1 | Transmit pump pull-up enable |
| tx_dn | output | 1 | Transmit pump pull-down enable |
| tx_hiz | output | 1 | Transmit pump floating |
| rx_up | output | 1 | Receive pump pull-up enable |
| rx_dn | output | 1 | Receive pump pull-down enable |
| rx_hiz | output | 1 | Receive pump floating |
| tx_lock_n | output | 1 | Transmit loop lock, low when locked |
| rx_lock_n | output | 1 | Receive loop lock, low when locked |
| status_out | output | 1 | Shared status pin |

## Verification
The bench builds the block with LOCK_WIN = 2 and LC_W = 3. The narrow window lets a lag of three cycles cross it, so lock loss while a pulse is still open (R8) shows up within a few cycles. The three-bit lock count lets lock_count reach its largest value, so the saturating good counter is exercised. A periodic stimulus with offsets of zero, one, minus one and three cycles moves both loops in and out of lock repeatedly. Sparse random strobes cover the repeated-edge and same-cycle cases.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_UP   = 2'd1,
    PH_DN   = 2'd2
  } pump_e;

  function automatic int unsigned err_width(input int unsigned win);
    return $clog2(win + 2);
  endfunction

endpackage

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
#(
  parameter int unsigned WIN = 3,
  parameter int unsigned CW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_stb,
  input  logic          fb_stb,
  output logic          pump_up,
  output logic          pump_dn,
  output logic          cmp_done,
  output logic [CW-1:0] cmp_err,
  output logic          overrun
);

  localparam logic [CW-1:0] WIN_C = CW'(WIN);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  pump_e         st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = (cnt_q > WIN_C) ? cnt_q : cnt_q + ONE_C;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    cmp_done = 1'b0;
    cmp_err  = '0;
    overrun  = 1'b0;
    case (st_q)
      PH_IDLE: begin
        if (ref_stb && fb_stb) begin
          cmp_done = 1'b1;
        end else if (ref_stb) begin
          st_d  = PH_UP;
          cnt_d = ONE_C;
        end else if (fb_stb) begin
          st_d  = PH_DN;
          cnt_d = ONE_C;
        end
      end
      PH_UP: begin
        if (fb_stb) begin
          cmp_done = 1'b1;
          cmp_err  = cnt_q;
          if (ref_stb) begin
            cnt_d = ONE_C;
          end else begin
            st_d  = PH_IDLE;
            cnt_d = '0;
          end
        end else begin
          overrun = (cnt_q >= WIN_C);
          cnt_d   = cnt_inc;
        end
      end
      PH_DN: begin
        if (ref_stb) begin
          cmp_done = 1'b1;
          cmp_err  = cnt_q;
          if (fb_stb) begin
            cnt_d = ONE_C;
          end else begin
            st_d  = PH_IDLE;
            cnt_d = '0;
          end
        end else begin
          overrun = (cnt_q >= WIN_C);
          cnt_d   = cnt_inc;
        end
      end
      default: begin
        st_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign pump_up = (st_q == PH_UP);
  assign pump_dn = (st_q == PH_DN);

  p_pump_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn));

  p_lag_opens_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pump_up && !pump_dn && ref_stb && !fb_stb) |=> (pump_up && !pump_dn));

  p_lead_opens_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pump_up && !pump_dn && fb_stb && !ref_stb) |=> (pump_dn && !pump_up));

  p_coincident_floats_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pump_up && !pump_dn && fb_stb && ref_stb) |=> (!pump_dn && !pump_up));

  p_up_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up && !fb_stb) |=> pump_up);

  p_up_closes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up && fb_stb && !ref_stb) |=> (!pump_up && !pump_dn));

  p_dn_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_dn && ref_stb && !fb_stb) |=> (!pump_up && !pump_dn));

  p_reopen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up && ref_stb && fb_stb) |=> pump_up);

endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
  parameter int unsigned WIN  = 3,
  parameter int unsigned CW   = 3,
  parameter int unsigned LC_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmp_done,
  input  logic [CW-1:0]   cmp_err,
  input  logic            overrun,
  input  logic [LC_W-1:0] lock_count,
  output logic            lock_n
);

  localparam logic [CW-1:0]   WIN_C = CW'(WIN);
  localparam logic [LC_W-1:0] ONE_L = LC_W'(1);

  logic [LC_W-1:0] good_q, good_inc, thr;
  logic            locked_q;
  logic            bad_evt, good_evt;

  assign thr      = (lock_count == '0) ? ONE_L : lock_count;
  assign good_inc = (&good_q) ? good_q : good_q + ONE_L;
  assign bad_evt  = overrun || (cmp_done && (cmp_err > WIN_C));
  assign good_evt = cmp_done && !bad_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q   <= '0;
      locked_q <= 1'b0;
    end else if (bad_evt) begin
      good_q   <= '0;
      locked_q <= 1'b0;
    end else if (good_evt) begin
      good_q   <= good_inc;
      locked_q <= locked_q || (good_inc >= thr);
    end
  end

  assign lock_n = !locked_q;

  p_bad_drops_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> lock_n);

  p_lock_after_good_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_n) |-> $past(good_evt));

endmodule

// File: rtl/pfd_loop.sv
module pfd_loop #(
  parameter int unsigned WIN  = 3,
  parameter int unsigned CW   = 3,
  parameter int unsigned LC_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_stb,
  input  logic            fb_stb,
  input  logic [LC_W-1:0] lock_count,
  output logic            pump_up,
  output logic            pump_dn,
  output logic            lock_n
);

  logic          cmp_done;
  logic [CW-1:0] cmp_err;
  logic          overrun;

  pfd_core #(.WIN(WIN), .CW(CW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_stb  (ref_stb),
    .fb_stb   (fb_stb),
    .pump_up  (pump_up),
    .pump_dn  (pump_dn),
    .cmp_done (cmp_done),
    .cmp_err  (cmp_err),
    .overrun  (overrun)
  );

  pfd_lock_det #(.WIN(WIN), .CW(CW), .LC_W(LC_W)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_done   (cmp_done),
    .cmp_err    (cmp_err),
    .overrun    (overrun),
    .lock_count (lock_count),
    .lock_n     (lock_n)
  );

endmodule

// File: rtl/pfd_lock_pair.sv
module pfd_lock_pair
  import pfd_pkg::*;
#(
  parameter int unsigned LOCK_WIN = 3,
  parameter int unsigned LC_W     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_ref_stb,
  input  logic            tx_fb_stb,
  input  logic            rx_ref_stb,
  input  logic            rx_fb_stb,
  input  logic [LC_W-1:0] lock_count,
  input  logic            status_sel,
  input  logic            carrier_det,
  output logic            tx_up,
  output logic            tx_dn,
  output logic            tx_hiz,
  output logic            rx_up,
  output logic            rx_dn,
  output logic            rx_hiz,
  output logic            tx_lock_n,
  output logic            rx_lock_n,
  output logic            status_out
);

  localparam int unsigned NUM_LOOPS = 2;
  localparam int unsigned ERR_W     = err_width(LOCK_WIN);

  logic [NUM_LOOPS-1:0] ref_v, fb_v, up_v, dn_v, lockn_v;

  assign ref_v = {rx_ref_stb, tx_ref_stb};
  assign fb_v  = {rx_fb_stb, tx_fb_stb};

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
    pfd_loop #(.WIN(LOCK_WIN), .CW(ERR_W), .LC_W(LC_W)) u_loop (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_stb    (ref_v[g]),
      .fb_stb     (fb_v[g]),
      .lock_count (lock_count),
      .pump_up    (up_v[g]),
      .pump_dn    (dn_v[g]),
      .lock_n     (lockn_v[g])
    );
  end

  assign tx_up     = up_v[0];
  assign tx_dn     = dn_v[0];
  assign tx_hiz    = !(up_v[0] || dn_v[0]);
  assign rx_up     = up_v[1];
  assign rx_dn     = dn_v[1];
  assign rx_hiz    = !(up_v[1] || dn_v[1]);
  assign tx_lock_n = lockn_v[0];
  assign rx_lock_n = lockn_v[1];

  assign status_out = status_sel ? lockn_v[0] : carrier_det;

  p_tx_rx_separate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ref_stb && !rx_fb_stb && !rx_up && !rx_dn) |=> (!rx_up && !rx_dn));

endmodule

// File: tb/pfd_lock_pair_tb.sv
module pfd_lock_pair_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 2;
  localparam int LCW        = 3;
  localparam int GMAX       = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_ref_stb = 0, tx_fb_stb = 0, rx_ref_stb = 0, rx_fb_stb = 0;
  logic [LCW-1:0] lock_count = '0;
  logic status_sel = 0, carrier_det = 0;
  logic tx_up, tx_dn, tx_hiz, rx_up, rx_dn, rx_hiz, tx_lock_n, rx_lock_n, status_out;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  logic m_up [2];
  logic m_dn [2];
  int   m_cnt[2];
  int   m_good[2];
  logic m_lock[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_lock_pair #(.LOCK_WIN(WIN), .LC_W(LCW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_ref_stb(tx_ref_stb), .tx_fb_stb(tx_fb_stb),
    .rx_ref_stb(rx_ref_stb), .rx_fb_stb(rx_fb_stb),
    .lock_count(lock_count), .status_sel(status_sel), .carrier_det(carrier_det),
    .tx_up(tx_up), .tx_dn(tx_dn), .tx_hiz(tx_hiz),
    .rx_up(rx_up), .rx_dn(rx_dn), .rx_hiz(rx_hiz),
    .tx_lock_n(tx_lock_n), .rx_lock_n(rx_lock_n), .status_out(status_out)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_up[i] = 0; m_dn[i] = 0; m_cnt[i] = 0; m_good[i] = 0; m_lock[i] = 0;
    end
  endtask

  task automatic model_step(input int i, input bit r, input bit f, input int lc);
    int thr;
    bit fin;
    int err;
    bit bad;
    thr = (lc == 0) ? 1 : lc;
    fin = 0; err = 0; bad = 0;
    if (!m_up[i] && !m_dn[i]) begin
      if (r && f) fin = 1;
      else if (r) begin m_up[i] = 1; m_cnt[i] = 1; end
      else if (f) begin m_dn[i] = 1; m_cnt[i] = 1; end
    end else if (m_up[i]) begin
      if (f) begin
        fin = 1; err = m_cnt[i];
        if (r) m_cnt[i] = 1; else begin m_up[i] = 0; m_cnt[i] = 0; end
      end else begin
        if (m_cnt[i] >= WIN) bad = 1;
        if (m_cnt[i] <= WIN) m_cnt[i]++;
      end
    end else begin
      if (r) begin
        fin = 1; err = m_cnt[i];
        if (f) m_cnt[i] = 1; else begin m_dn[i] = 0; m_cnt[i] = 0; end
      end else begin
        if (m_cnt[i] >= WIN) bad = 1;
        if (m_cnt[i] <= WIN) m_cnt[i]++;
      end
    end
    if (fin && err > WIN) bad = 1;
    if (bad) begin
      m_good[i] = 0; m_lock[i] = 0;
    end else if (fin) begin
      if (m_good[i] < GMAX) m_good[i]++;
      if (m_good[i] >= thr) m_lock[i] = 1;
    end
  endtask

  // Drive at negedge, let one posedge pass, update model, compare at posedge+1.
  task automatic cyc(input bit tr, input bit tf, input bit rr, input bit rf);
    int lc;
    tx_ref_stb = tr; tx_fb_stb = tf; rx_ref_stb = rr; rx_fb_stb = rf;
    lc = int'(lock_count);
    @(posedge clk);
    #1;
    model_step(0, tr, tf, lc);
    model_step(1, rr, rf, lc);
    chk("R1 tx_up", tx_up, m_up[0]);
    chk("R2 tx_dn", tx_dn, m_dn[0]);
    chk("R5 tx_hiz", tx_hiz, !(m_up[0] || m_dn[0]));
    chk("R7 tx_lock_n", tx_lock_n, !m_lock[0]);
    chk("R1 rx_up", rx_up, m_up[1]);
    chk("R2 rx_dn", rx_dn, m_dn[1]);
    chk("R5 rx_hiz", rx_hiz, !(m_up[1] || m_dn[1]));
    chk("R7 rx_lock_n", rx_lock_n, !m_lock[1]);
    chk("R10 status_out", status_out, status_sel ? !m_lock[0] : carrier_det);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int off;
    void'($urandom(32'd4242));
    model_reset();
    lock_count = 3'd2;
    status_sel = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 tx_up", tx_up, 0);
    chk("R9 tx_dn", tx_dn, 0);
    chk("R9 tx_hiz", tx_hiz, 1);
    chk("R9 tx_lock_n", tx_lock_n, 1);
    chk("R9 rx_hiz", rx_hiz, 1);
    chk("R9 rx_lock_n", rx_lock_n, 1);

    // R1 lag of two cycles: good comparison, not yet locked
    cyc(1,0,0,0);
    cyc(0,0,0,0);
    chk("R1 up held during lag", tx_up, 1);
    cyc(0,1,0,0);
    chk("R1 up closed", tx_up, 0);
    chk("R7 one good not locked", tx_lock_n, 1);
    // R2 lead of one cycle: second good comparison locks
    cyc(0,1,0,0);
    chk("R2 dn open", tx_dn, 1);
    chk("R2 up low during lead", tx_up, 0);
    cyc(1,0,0,0);
    chk("R7 locked after two good", tx_lock_n, 0);
    chk("R10 pin shows tx lock", status_out, 0);
    // R3 coincident strobes
    cyc(1,1,0,0);
    chk("R3 hiz on coincidence", tx_hiz, 1);
    chk("R3 no up", tx_up, 0);
    chk("R3 no dn", tx_dn, 0);
    // R8 open pulse reaches window
    cyc(1,0,0,0);
    cyc(0,0,0,0);
    chk("R8 still locked inside window", tx_lock_n, 0);
    cyc(0,0,0,0);
    chk("R8 lock dropped at window", tx_lock_n, 1);
    chk("R8 up still open", tx_up, 1);
    // R4 repeated reference strobe keeps up
    cyc(1,0,0,0);
    chk("R4 up kept", tx_up, 1);
    chk("R4 dn low", tx_dn, 0);
    cyc(0,1,0,0);
    // R6 coincident strobes while open
    cyc(1,0,0,0);
    cyc(1,1,0,0);
    chk("R6 up reopened", tx_up, 1);
    cyc(0,1,0,0);
    chk("R6 up closed", tx_up, 0);
    // R11 receive strobes leave transmit idle
    cyc(0,0,1,0);
    chk("R11 rx up", rx_up, 1);
    chk("R11 tx unaffected", tx_hiz, 1);
    cyc(0,0,0,1);
    chk("R11 rx closed", rx_hiz, 1);
    // R10 carrier path
    status_sel = 0; carrier_det = 1;
    cyc(0,0,0,0);
    chk("R10 carrier high", status_out, 1);
    carrier_det = 0;
    cyc(0,0,0,0);
    chk("R10 carrier low", status_out, 0);

    // sparse random strobes
    for (int c = 0; c < 1500; c++) begin
      if (c % 100 == 0) lock_count = 3'($urandom_range(0, 7));
      status_sel  = 1'($urandom_range(0, 1));
      carrier_det = 1'($urandom_range(0, 1));
      cyc(($urandom_range(0,5) == 0), ($urandom_range(0,5) == 0),
          ($urandom_range(0,5) == 0), ($urandom_range(0,5) == 0));
    end

    // periodic strobes with jittered feedback offset
    off = 0;
    for (int c = 0; c < 2400; c++) begin
      int ph;
      int sel;
      ph = c % 8;
      if (c % 400 == 0) lock_count = 3'($urandom_range(0, 7));
      if (ph == 0) begin
        sel = int'($urandom_range(0, 9));
        off = (sel < 4) ? 0 : (sel < 7) ? 1 : (sel < 9) ? 7 : 3;
      end
      status_sel = 1;
      cyc(ph == 0, ph == off, ph == 0, ph == ((off + 1) % 8));
    end

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule